// File: doc/BRIEF.md
# Floating-Point Add/Subtract Unit

This block adds or subtracts two signed floating-point operands. Each operand has a sign bit, an 11-bit biased exponent and a 32-bit mantissa in 1.31 form: one integer bit, then 31 fraction bits. Operands are expected to be normalized, with the integer bit set. The block subtracts the exponents in an 11-bit subtractor and keeps the larger exponent as the starting exponent of the result. It shifts the mantissa of the smaller operand right by the exponent difference and keeps a guard bit, a round bit and a sticky bit. The aligned mantissas are then combined in a wide adder/subtractor. The result is normalized in either direction and rounded to a 32-bit or a 24-bit mantissa precision, with the precision chosen per operation.

An operation is launched by a one-cycle `start_i` pulse. A new operation may be launched on every cycle. The first pipeline stage compares, aligns and adds. The second normalizes and rounds, and it registers the result together with a `valid_o` pulse. The arithmetic lives in functions, so each step can be restated outside the design. Internal events are brought out as named wires for the assertions: add carry-out, rounding increment and rounding overflow.

Top module: `fp_addsub`

## Requirements
- R1: The result exponent starts from the larger operand exponent. A same-sign add whose aligned sum does not carry out and is not rounded up returns exactly the larger exponent.
- R2: The mantissa of the operand with the smaller exponent is shifted right by the exponent difference before the add. For example, exponents 10 and 13 give a 3-position shift of the first operand. The result equals the exactly rounded sum of the two values.
- R3: When the alignment distance is 64 or more, the shifted mantissa contributes only a sticky bit. Toward-zero rounding then returns the larger operand unchanged on an add, and toward-plus-infinity rounding returns it raised by one unit in the last place.
- R4: A carry out of the mantissa sum shifts the sum right by one position and adds 1 to the exponent.
- R5: Leading zeros after a subtraction are removed by a left shift, and the exponent is reduced by the shift count. A nonzero result always has mantissa bit 31 set.
- R6: `prec24_i`=1 rounds to a 24-bit mantissa held in bits 31:8, with bits 7:0 returned as zero. `prec24_i`=0 rounds to all 32 bits.
- R7: `rmode_i` selects the rounding: 00 round to nearest with ties to even, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity. Rounding uses the first dropped bit and the OR of all lower dropped bits.
- R8: When rounding carries out of the mantissa, the mantissa becomes 0x80000000 and the exponent is incremented once more. This can happen in the same operation as an R4 carry.
- R9: When the effective operation is a subtraction, the result sign follows the operand of larger magnitude. The second operand's effective sign is `b_sign_i` XOR `sub_i`. An exactly zero result is returned as sign 0, exponent 0, mantissa 0.
- R10: `valid_o` is high for exactly one cycle, two clock cycles after each `start_i` pulse. Operations may be issued on consecutive cycles, and their results come out in issue order.
- R11: After reset, `valid_o` is low and the result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch an operation this cycle |
| sub_i | input | 1 | 1 subtracts operand B from operand A, 0 adds them |
| prec24_i | input | 1 | 1 selects 24-bit rounding precision, 0 selects 32-bit |
| rmode_i | input | 2 | Rounding mode (encoding in R7) |
| a_sign_i | input | 1 | Sign of operand A |
| a_exp_i | input | 11 | Biased exponent of operand A |
| a_mant_i | input | 32 | Mantissa of operand A, 1.31 form |
| b_sign_i | input | 1 | Sign of operand B |
| b_exp_i | input | 11 | Biased exponent of operand B |
| b_mant_i | input | 32 | Mantissa of operand B, 1.31 form |
| valid_o | output | 1 | Result valid pulse |
| res_sign_o | output | 1 | Result sign |
| res_exp_o | output | 11 | Result biased exponent |
| res_mant_o | output | 32 | Result mantissa, 1.31 form |

## Verification
The add carry-out normalization of R4 and the rounding overflow of R8 can both occur in one operation. The bench provokes this with two equal-exponent operands of mantissa 0xFFFFFFC0 at 24-bit precision. That sum carries out, and its shifted value then rounds up past the top of the mantissa. It is judged by an exact reference model that computes the sum as a wide integer and rounds it once. The expected result is mantissa 0x80000000 with the exponent raised by two, and an assertion ties every rounding overflow to that mantissa.

// File: rtl/fpas_pkg.sv
package fpas_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_ZERO    = 2'b01,
    RM_DOWN    = 2'b10,
    RM_UP      = 2'b11
  } rmode_e;

  // Decide the rounding increment from the kept LSB, the first dropped
  // bit and the OR of everything below it.
  function automatic logic round_up_f(input rmode_e rm, input logic sign,
                                      input logic lsb, input logic g,
                                      input logic st);
    logic up;
    case (rm)
      RM_NEAREST: up = g & (st | lsb);
      RM_ZERO:    up = 1'b0;
      RM_DOWN:    up = (g | st) & sign;
      default:    up = (g | st) & ~sign;
    endcase
    return up;
  endfunction

endpackage

// File: rtl/fpas_align_add.sv
module fpas_align_add #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 32
) (
  input  logic                 a_sign,
  input  logic [EXP_W-1:0]     a_exp,
  input  logic [MAN_W-1:0]     a_mant,
  input  logic                 b_sign,
  input  logic [EXP_W-1:0]     b_exp,
  input  logic [MAN_W-1:0]     b_mant,
  input  logic                 sub,
  output logic [MAN_W+3:0]     sum,
  output logic [EXP_W-1:0]     big_exp,
  output logic                 res_sign,
  output logic                 carry_ev
);
  localparam int EXT_W = MAN_W + 3;
  localparam int SUM_W = EXT_W + 1;
  localparam int WIN_W = 2 * MAN_W;
  localparam logic [EXP_W-1:0] WIN_LIM = EXP_W'(WIN_W);

  // Shift the mantissa right across a double-width window; the first two
  // bits below the mantissa become guard and round, the rest fold to sticky.
  function automatic logic [EXT_W-1:0] align_f(input logic [MAN_W-1:0] m,
                                               input logic [EXP_W-1:0] sh);
    logic [WIN_W-1:0] win;
    if (sh >= WIN_LIM) return {{(EXT_W-1){1'b0}}, |m};
    win = {m, {MAN_W{1'b0}}} >> sh;
    return {win[WIN_W-1:MAN_W-2], |win[MAN_W-3:0]};
  endfunction

  logic [EXP_W:0]     diff_ab, diff_ba;
  logic               a_big, eff_sub;
  logic [EXP_W-1:0]   shamt;
  logic [MAN_W-1:0]   big_m, small_m;
  logic [EXT_W-1:0]   small_al;
  logic [SUM_W-1:0]   big_x, small_x;

  always_comb begin
    diff_ab  = {1'b0, a_exp} - {1'b0, b_exp};
    diff_ba  = {1'b0, b_exp} - {1'b0, a_exp};
    a_big    = ~diff_ab[EXP_W] & ((a_exp != b_exp) | (a_mant >= b_mant));
    shamt    = a_big ? diff_ab[EXP_W-1:0] : diff_ba[EXP_W-1:0];
    big_exp  = a_big ? a_exp : b_exp;
    big_m    = a_big ? a_mant : b_mant;
    small_m  = a_big ? b_mant : a_mant;
    small_al = align_f(small_m, shamt);
    eff_sub  = a_sign ^ b_sign ^ sub;
    big_x    = {1'b0, big_m, 3'b000};
    small_x  = {1'b0, small_al};
    sum      = eff_sub ? big_x - small_x : big_x + small_x;
    res_sign = a_big ? a_sign : (b_sign ^ sub);
    carry_ev = sum[SUM_W-1];
  end

endmodule

// File: rtl/fpas_norm_round.sv
module fpas_norm_round
  import fpas_pkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int MAN_W    = 32,
  parameter int NARROW_W = 24
) (
  input  logic [MAN_W+3:0]   sum,
  input  logic [EXP_W-1:0]   exp_in,
  input  logic               sign_in,
  input  logic               narrow,
  input  rmode_e             rm,
  output logic               sign_out,
  output logic [EXP_W-1:0]   exp_out,
  output logic [MAN_W-1:0]   mant_out,
  output logic               round_up_ev,
  output logic               round_ovf_ev
);
  localparam int EXT_W = MAN_W + 3;
  localparam int SUM_W = EXT_W + 1;
  localparam int DROP  = MAN_W - NARROW_W;
  localparam int LZW   = $clog2(EXT_W + 1);

  function automatic logic [LZW-1:0] lzc_f(input logic [EXT_W-1:0] v);
    logic [LZW-1:0] n;
    logic hit;
    n = '0;
    hit = 1'b0;
    for (int i = EXT_W - 1; i >= 0; i--) begin
      if (!hit && !v[i]) n = n + 1'b1;
      else hit = 1'b1;
    end
    return n;
  endfunction

  logic [LZW-1:0]   lz;
  logic [EXT_W-1:0] nrm;
  logic [EXP_W-1:0] e_n;
  logic [MAN_W-1:0] m_k, m_t;
  logic             lsb, g, st, is_zero;
  logic [MAN_W:0]   inc, rsum;

  always_comb begin
    lz = lzc_f(sum[EXT_W-1:0]);
    if (sum[SUM_W-1]) begin
      nrm = {sum[SUM_W-1:2], sum[1] | sum[0]};
      e_n = exp_in + 1'b1;
    end else begin
      nrm = sum[EXT_W-1:0] << lz;
      e_n = exp_in - EXP_W'(lz);
    end
    m_k = nrm[EXT_W-1:3];
    if (narrow) begin
      lsb = m_k[DROP];
      g   = m_k[DROP-1];
      st  = (|m_k[DROP-2:0]) | (|nrm[2:0]);
      m_t = {m_k[MAN_W-1:DROP], {DROP{1'b0}}};
      inc = (MAN_W+1)'(1) << DROP;
    end else begin
      lsb = m_k[0];
      g   = nrm[2];
      st  = nrm[1] | nrm[0];
      m_t = m_k;
      inc = (MAN_W+1)'(1);
    end
    round_up_ev  = round_up_f(rm, sign_in, lsb, g, st);
    rsum         = {1'b0, m_t} + (round_up_ev ? inc : '0);
    round_ovf_ev = rsum[MAN_W];
    is_zero      = (sum == '0);
    if (is_zero) begin
      sign_out = 1'b0;
      exp_out  = '0;
      mant_out = '0;
    end else begin
      sign_out = sign_in;
      exp_out  = round_ovf_ev ? e_n + 1'b1 : e_n;
      mant_out = round_ovf_ev ? {1'b1, {(MAN_W-1){1'b0}}} : rsum[MAN_W-1:0];
    end
  end

endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
  import fpas_pkg::*;
#(
  parameter int EXP_W    = 11,
  parameter int MAN_W    = 32,
  parameter int NARROW_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic              prec24_i,
  input  logic [1:0]        rmode_i,
  input  logic              a_sign_i,
  input  logic [EXP_W-1:0]  a_exp_i,
  input  logic [MAN_W-1:0]  a_mant_i,
  input  logic              b_sign_i,
  input  logic [EXP_W-1:0]  b_exp_i,
  input  logic [MAN_W-1:0]  b_mant_i,
  output logic              valid_o,
  output logic              res_sign_o,
  output logic [EXP_W-1:0]  res_exp_o,
  output logic [MAN_W-1:0]  res_mant_o
);
  localparam int SUM_W = MAN_W + 4;

  // Stage 1: compare, align, add
  logic [SUM_W-1:0] c_sum;
  logic [EXP_W-1:0] big_exp;
  logic             c_sign;
  logic             ev_add_carry;

  fpas_align_add #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .a_sign(a_sign_i), .a_exp(a_exp_i), .a_mant(a_mant_i),
    .b_sign(b_sign_i), .b_exp(b_exp_i), .b_mant(b_mant_i),
    .sub(sub_i), .sum(c_sum), .big_exp(big_exp),
    .res_sign(c_sign), .carry_ev(ev_add_carry)
  );

  logic             s1_valid, s1_sign, s1_narrow;
  logic [SUM_W-1:0] s1_sum;
  logic [EXP_W-1:0] s1_exp;
  rmode_e           s1_rm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_sum    <= '0;
      s1_exp    <= '0;
      s1_sign   <= 1'b0;
      s1_narrow <= 1'b0;
      s1_rm     <= RM_NEAREST;
    end else begin
      s1_valid <= start_i;
      if (start_i) begin
        s1_sum    <= c_sum;
        s1_exp    <= big_exp;
        s1_sign   <= c_sign;
        s1_narrow <= prec24_i;
        s1_rm     <= rmode_e'(rmode_i);
      end
    end
  end

  // Stage 2: normalize, round
  logic             n_sign;
  logic [EXP_W-1:0] n_exp;
  logic [MAN_W-1:0] n_mant;
  logic             ev_round_up, ev_round_ovf;

  fpas_norm_round #(.EXP_W(EXP_W), .MAN_W(MAN_W), .NARROW_W(NARROW_W)) u_norm (
    .sum(s1_sum), .exp_in(s1_exp), .sign_in(s1_sign),
    .narrow(s1_narrow), .rm(s1_rm),
    .sign_out(n_sign), .exp_out(n_exp), .mant_out(n_mant),
    .round_up_ev(ev_round_up), .round_ovf_ev(ev_round_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o    <= 1'b0;
      res_sign_o <= 1'b0;
      res_exp_o  <= '0;
      res_mant_o <= '0;
    end else begin
      valid_o <= s1_valid;
      if (s1_valid) begin
        res_sign_o <= n_sign;
        res_exp_o  <= n_exp;
        res_mant_o <= n_mant;
      end
    end
  end

endmodule

// File: rtl/fpas_checker.sv
module fpas_checker #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             prec24_i,
  input logic [EXP_W-1:0] a_exp_i,
  input logic [EXP_W-1:0] b_exp_i,
  input logic [EXP_W-1:0] big_exp,
  input logic [1:0]       s1_rm,
  input logic             ev_round_up,
  input logic             ev_round_ovf,
  input logic             valid_o,
  input logic             res_sign_o,
  input logic [EXP_W-1:0] res_exp_o,
  input logic [MAN_W-1:0] res_mant_o
);

  // R1: the chosen starting exponent is never below either operand
  p_big_exp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (big_exp >= a_exp_i) && (big_exp >= b_exp_i));

  // R5: nonzero results are normalized
  p_normalized_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && res_mant_o != '0) |-> res_mant_o[MAN_W-1]);

  // R6: narrow precision clears the low mantissa byte
  p_narrow_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(prec24_i, 2)) |-> (res_mant_o[7:0] == 8'h00));

  // R7: toward-zero never increments
  p_rz_no_inc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_rm == 2'b01) |-> !ev_round_up);

  // R8: a rounding overflow leaves the minimal normalized mantissa
  p_round_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_round_ovf) && valid_o |-> (res_mant_o == {1'b1, {(MAN_W-1){1'b0}}}));

  // R9: zero results have canonical encoding
  p_zero_canon_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && res_mant_o == '0) |-> (res_exp_o == '0) && !res_sign_o);

  // R10: latency of two cycles, both directions
  p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> ##2 valid_o);
  p_valid_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(start_i, 2));

endmodule

bind fp_addsub fpas_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .prec24_i(prec24_i),
  .a_exp_i(a_exp_i), .b_exp_i(b_exp_i), .big_exp(big_exp),
  .s1_rm(s1_rm), .ev_round_up(ev_round_up), .ev_round_ovf(ev_round_ovf),
  .valid_o(valid_o), .res_sign_o(res_sign_o), .res_exp_o(res_exp_o),
  .res_mant_o(res_mant_o)
);

// File: tb/tb_fp_addsub.sv
module tb_fp_addsub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, sub_i = 1'b0, prec24_i = 1'b0;
  logic [1:0]  rmode_i = 2'b00;
  logic        a_sign_i = 1'b0, b_sign_i = 1'b0;
  logic [10:0] a_exp_i = '0, b_exp_i = '0;
  logic [31:0] a_mant_i = '0, b_mant_i = '0;
  logic        valid_o, res_sign_o;
  logic [10:0] res_exp_o;
  logic [31:0] res_mant_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  fp_addsub dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
    .prec24_i(prec24_i), .rmode_i(rmode_i),
    .a_sign_i(a_sign_i), .a_exp_i(a_exp_i), .a_mant_i(a_mant_i),
    .b_sign_i(b_sign_i), .b_exp_i(b_exp_i), .b_mant_i(b_mant_i),
    .valid_o(valid_o), .res_sign_o(res_sign_o),
    .res_exp_o(res_exp_o), .res_mant_o(res_mant_o)
  );

  // Exact reference: both operands as wide integers on a common scale,
  // one exact sum, then a single rounding step.
  function automatic logic [43:0] model(
      input logic sa, input logic [10:0] ea, input logic [31:0] ma,
      input logic sb, input logic [10:0] eb, input logic [31:0] mb,
      input logic sub, input logic narrow, input logic [1:0] rm);
    logic [255:0] x, y, s, q;
    logic sgn, sb2, g, st, up;
    int emin, p, pw, sh, e;
    emin = (ea < eb) ? int'(ea) : int'(eb);
    x = 256'(ma) << (int'(ea) - emin);
    y = 256'(mb) << (int'(eb) - emin);
    sb2 = sb ^ sub;
    if (sa == sb2) begin s = x + y; sgn = sa; end
    else if (x >= y) begin s = x - y; sgn = sa; end
    else begin s = y - x; sgn = sb2; end
    if (s == '0) return '0;
    p = 0;
    for (int i = 0; i < 256; i++) if (s[i]) p = i;
    pw = narrow ? 24 : 32;
    if (p >= pw - 1) begin
      sh = p - pw + 1;
      q  = s >> sh;
      g  = (sh > 0) ? s[sh-1] : 1'b0;
      st = (sh > 1) ? |(s & ((256'(1) << (sh - 1)) - 256'(1))) : 1'b0;
    end else begin
      q = s << (pw - 1 - p);
      g = 1'b0;
      st = 1'b0;
    end
    case (rm)
      2'b00: up = g & (st | q[0]);
      2'b01: up = 1'b0;
      2'b10: up = (g | st) & sgn;
      default: up = (g | st) & ~sgn;
    endcase
    q = q + 256'(up);
    e = emin + p - 31;
    if (q == (256'(1) << pw)) begin
      q = 256'(1) << (pw - 1);
      e = e + 1;
    end
    q = q << (32 - pw);
    return {sgn, 11'(e), q[31:0]};
  endfunction

  task automatic check(input string req, input logic [43:0] got,
                       input logic [43:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic sa, input logic [10:0] ea, input logic [31:0] ma,
                       input logic sb, input logic [10:0] eb, input logic [31:0] mb,
                       input logic sub, input logic narrow, input logic [1:0] rm);
    a_sign_i = sa; a_exp_i = ea; a_mant_i = ma;
    b_sign_i = sb; b_exp_i = eb; b_mant_i = mb;
    sub_i = sub; prec24_i = narrow; rmode_i = rm;
    start_i = 1'b1;
  endtask

  // One operation; result sampled two edges later at a falling edge.
  task automatic op(input string req,
                    input logic sa, input logic [10:0] ea, input logic [31:0] ma,
                    input logic sb, input logic [10:0] eb, input logic [31:0] mb,
                    input logic sub, input logic narrow, input logic [1:0] rm,
                    output logic [43:0] got);
    @(negedge clk);
    drive(sa, ea, ma, sb, eb, mb, sub, narrow, rm);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    check({req, " valid"}, {43'd0, valid_o}, 44'd1);
    got = {res_sign_o, res_exp_o, res_mant_o};
    check(req, got, model(sa, ea, ma, sb, eb, mb, sub, narrow, rm));
  endtask

  task automatic t_reset;
    check("R11 reset state", {valid_o, res_sign_o, res_exp_o, res_mant_o[30:0]}, 44'd0);
    check("R11 reset mant top", {43'd0, res_mant_o[31]}, 44'd0);
  endtask

  task automatic t_exp_compare;
    logic [43:0] r;
    op("R1 larger exponent kept", 0, 11'd13, 32'h8000_0000, 0, 11'd10, 32'h8000_0000,
       0, 0, 2'b00, r);
    check("R1 exponent/mantissa", r, {1'b0, 11'd13, 32'h9000_0000});
  endtask

  task automatic t_align;
    logic [43:0] r;
    op("R2 first operand shifted by 3", 0, 11'd10, 32'hF000_0001, 0, 11'd13, 32'h8000_0003,
       0, 0, 2'b00, r);
    op("R2 shift 5 with sticky", 0, 11'd300, 32'hC000_0007, 0, 11'd295, 32'hFFFF_FFFF,
       0, 0, 2'b00, r);
  endtask

  task automatic t_far;
    logic [43:0] r;
    op("R3 far operand RZ", 0, 11'd400, 32'h8000_0000, 0, 11'd300, 32'hFFFF_FFFF,
       0, 0, 2'b01, r);
    check("R3 RZ keeps larger", r, {1'b0, 11'd400, 32'h8000_0000});
    op("R3 far operand RP", 0, 11'd400, 32'h8000_0000, 0, 11'd300, 32'hFFFF_FFFF,
       0, 0, 2'b11, r);
    check("R3 RP adds one ulp", r, {1'b0, 11'd400, 32'h8000_0001});
    op("R3 far subtract RZ", 0, 11'd400, 32'h8000_0000, 0, 11'd330, 32'h8000_0000,
       1, 0, 2'b01, r);
  endtask

  task automatic t_carry;
    logic [43:0] r;
    op("R4 carry out", 0, 11'd50, 32'hC000_0000, 0, 11'd50, 32'hC000_0000,
       0, 0, 2'b00, r);
    check("R4 exponent incremented", r, {1'b0, 11'd51, 32'hC000_0000});
    op("R4 carry odd tie", 0, 11'd50, 32'hFFFF_FFFF, 0, 11'd50, 32'h8000_0000,
       0, 0, 2'b00, r);
  endtask

  task automatic t_cancel;
    logic [43:0] r;
    op("R5 deep cancel", 0, 11'd100, 32'h8000_0001, 0, 11'd100, 32'h8000_0000,
       1, 0, 2'b00, r);
    check("R5 left normalized", r, {1'b0, 11'd69, 32'h8000_0000});
    op("R5 one-off cancel", 0, 11'd100, 32'h8000_0000, 0, 11'd99, 32'hFFFF_FFFF,
       1, 0, 2'b00, r);
  endtask

  task automatic t_narrow;
    logic [43:0] r;
    op("R6 narrow precision", 0, 11'd70, 32'h8123_45FF, 0, 11'd70, 32'h8000_0081,
       0, 1, 2'b00, r);
    op("R6 narrow RP", 1, 11'd70, 32'h9876_5432, 0, 11'd66, 32'hABCD_EF01,
       0, 1, 2'b11, r);
  endtask

  task automatic t_modes;
    logic [43:0] r;
    for (int m = 0; m < 4; m++) begin
      op("R7 mode positive", 0, 11'd200, 32'h8000_0000, 0, 11'd198, 32'h8000_0006,
         0, 0, 2'(m), r);
      op("R7 mode negative", 1, 11'd200, 32'h8000_0000, 1, 11'd198, 32'h8000_0006,
         0, 0, 2'(m), r);
    end
    op("R7 nearest tie even", 0, 11'd200, 32'h8000_0000, 0, 11'd199, 32'h8000_0001,
       0, 0, 2'b00, r);
  endtask

  task automatic t_round_ovf;
    logic [43:0] r;
    op("R8 carry plus rounding overflow", 0, 11'd10, 32'hFFFF_FFC0, 0, 11'd10, 32'hFFFF_FFC0,
       0, 1, 2'b00, r);
    check("R8 renormalized", r, {1'b0, 11'd12, 32'h8000_0000});
    op("R8 rounding overflow 32", 0, 11'd40, 32'hFFFF_FFFF, 0, 11'd8, 32'h8000_0000,
       0, 0, 2'b11, r);
  endtask

  task automatic t_sign;
    logic [43:0] r;
    op("R9 larger magnitude sign", 0, 11'd90, 32'h8000_0000, 0, 11'd92, 32'hA000_0000,
       1, 0, 2'b00, r);
    check("R9 sign negative", {43'd0, r[43]}, 44'd1);
    op("R9 exact zero", 1, 11'd90, 32'hA5A5_A5A5, 1, 11'd90, 32'hA5A5_A5A5,
       1, 0, 2'b10, r);
    check("R9 zero encoding", r, 44'd0);
  endtask

  task automatic t_pipeline;
    logic [43:0] e1, e2;
    e1 = model(0, 11'd20, 32'h8000_0000, 0, 11'd20, 32'h8000_0000, 0, 0, 2'b00);
    e2 = model(0, 11'd30, 32'h9000_0000, 0, 11'd25, 32'h8000_0000, 1, 0, 2'b00);
    @(negedge clk);
    drive(0, 11'd20, 32'h8000_0000, 0, 11'd20, 32'h8000_0000, 0, 0, 2'b00);
    @(negedge clk);
    drive(0, 11'd30, 32'h9000_0000, 0, 11'd25, 32'h8000_0000, 1, 0, 2'b00);
    @(negedge clk);
    start_i = 1'b0;
    check("R10 first valid", {43'd0, valid_o}, 44'd1);
    check("R10 first result", {res_sign_o, res_exp_o, res_mant_o}, e1);
    @(negedge clk);
    check("R10 second valid", {43'd0, valid_o}, 44'd1);
    check("R10 second result", {res_sign_o, res_exp_o, res_mant_o}, e2);
    @(negedge clk);
    check("R10 valid drops", {43'd0, valid_o}, 44'd0);
  endtask

  task automatic t_sweep;
    logic [43:0] r;
    for (int k = 0; k < 300; k++) begin
      logic [10:0] ea, eb;
      ea = 11'(200 + ($urandom % 100));
      eb = 11'(200 + ($urandom % 100));
      op("R7 sweep", 1'($urandom), ea, 32'h8000_0000 | $urandom,
         1'($urandom), eb, 32'h8000_0000 | $urandom,
         1'($urandom), 1'($urandom), 2'($urandom), r);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_exp_compare();
    t_align();
    t_far();
    t_carry();
    t_cancel();
    t_narrow();
    t_modes();
    t_round_ovf();
    t_sign();
    t_pipeline();
    t_sweep();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule